// File: doc/BRIEF.md
# Normalizing Residual Recursion Datapath

This block keeps the 8-bit residual of a shared continued-product engine. The same engine computes a quotient, a product, a natural logarithm or an exponential. The residual is a two's complement fraction with one sign bit and seven fraction bits. Each recursion step drives the residual toward zero. On every step the block picks a redundant digit S in {-1, 0, +1} from the four top bits of the residual. The digit is offered to a companion function datapath, which builds the result from the same digit and the same step index.

A surrounding controller first sets the opcode. It then pulses `load` with an already range-reduced starting value, which sets the step index to 1. After that it issues one `step` strobe per recursion. The opcode says how the residual is updated:
- Division and logarithm add a shifted copy of the residual.
- Multiplication only flips a sign.
- Exponentiation adds a step-indexed constant, and the block doubles the result on the following clock by itself.

`done` marks the last useful step. From then on, strobes are dropped until the next load. None of these pins is a data stream, so there is no valid/ready handshake and no back-pressure. The controller must not expect a strobe given while a doubling is pending, or after `done`, to be queued.

Top module: `resid_norm_core`

## Requirements
- R1: While `rst_n` is low, `resid` reads 0, `step_idx` reads 1 and `done` reads 0.
- R2: A clock edge with `load` high sets `resid` to `load_val`, sets `step_idx` to 1, clears `done` and cancels any pending doubling. `load` overrides `step` in the same cycle.
- R3: `dig_nz` is 1 exactly when `resid` is at least +3/8 (0x30 to 0x7F) or below -3/8 (0x80 to 0xCF). It is 0 for 0xD0 to 0x2F. Only `resid[7:4]` decide it.
- R4: `dig_neg` (S = -1) is 0 whenever `dig_nz` is 0. For opcode 3'b111 (divide) and 3'b101 (logarithm), S takes the sign opposite to `resid`. For opcode 3'b011 (multiply) and 3'b110 (exponential), S takes the same sign as `resid`.
- R5: An accepted step with S = 0 replaces `resid` with `resid` shifted left by one with a zero LSB, for every opcode, and advances `step_idx` by 1.
- R6: For divide and logarithm, an accepted step with S != 0 sets `resid` to 2u + S + S*(u >>> k) modulo 256. Here u >>> k is an arithmetic right shift by `step_idx`. The +S term is made by inverting bit 7 of 2u. S = -1 subtracts the shifted term through inversion plus a carry-in of 1.
- R7: For multiply, and for any opcode outside the four listed, an accepted step with S != 0 sets `resid` to 2u - S modulo 256. This is 2u with bit 7 inverted.
- R8: For exponential, an accepted step with S != 0 first sets `resid` to u + C(S,k) modulo 256 and leaves `step_idx` unchanged. On the very next edge `resid` doubles and `step_idx` advances, whatever `step` is. C(S,k) is 2^k*(-ln(1 + S*2^-(k+1))), scaled by 128 and rounded to nearest. For S=+1, k=1..7 it is 0xC7,0xC4,0xC2,0xC1,0xC0,0xC0,0xC0. For S=-1 it is 0x4A,0x44,0x42,0x41,0x41,0x40,0x40.
- R9: `step_idx` moves only on accepted steps (or the R8 doubling). `done` is high exactly when `step_idx` is 7, the point at which the next-step index reaches 8. While `done` is high, or while `step` is low, `resid` and `step_idx` hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_code | input | 3 | Operation: 111 divide, 011 multiply, 101 logarithm, 110 exponential |
| load | input | 1 | Load `load_val` and restart the step index |
| load_val | input | 8 | Range-reduced starting residual |
| step | input | 1 | Request one recursion step |
| resid | output | 8 | Current residual |
| dig_nz | output | 1 | Magnitude of the selected digit S |
| dig_neg | output | 1 | Sign of the selected digit (1 means S = -1) |
| step_idx | output | 3 | Current step index k |
| done | output | 1 | Index has reached its last value |

## Verification
The bench loads the threshold neighbours 0x2F, 0x30, 0xCF, 0xD0, 0x7F and 0x80 under every opcode. A selector whose comparison is off by one code would give a nonzero digit at -3/8, or a zero digit at +3/8. Exponential steps are followed by a strobe during the automatic doubling cycle. A design that doubles in the same cycle would hold a wrong residual. A design that accepts that strobe would advance the index twice. Long random sequences run past `done` and include `load` together with `step`. These catch a counter that wraps, steps taken after completion, and a load that loses to a step. A reference model with the constants computed from the logarithm exposes a swapped constant sign or a missing subtraction carry-in.

// File: rtl/rnr_pkg.sv
package rnr_pkg;
  // Opcode values; bit 2..0 of op_code
  typedef enum logic [2:0] {
    OP_DIV = 3'b111,
    OP_MUL = 3'b011,
    OP_LOG = 3'b101,
    OP_EXP = 3'b110
  } rnr_op_e;
endpackage

// File: rtl/rnr_digit_sel.sv
// Redundant digit choice from the four leading residual bits (R3, R4).
module rnr_digit_sel #(
  parameter int W = 8
) (
  input  logic [W-1:0] u,
  input  logic         toward_neg,  // 1: digit sign opposes residual sign
  output logic         nz,
  output logic         neg
);
  logic [3:0] top4;
  assign top4 = u[W-1 -: 4];

  always_comb begin
    if (top4[3]) nz = (top4[2:0] <= 3'b100);
    else         nz = (top4[2:0] >= 3'b011);
    neg = nz & (top4[3] ^ toward_neg);
  end
endmodule

// File: rtl/rnr_exp_const.sv
// Step-indexed exponential correction constants (R8).
module rnr_exp_const #(
  parameter int W  = 8,
  parameter int KW = 3
) (
  input  logic          neg,
  input  logic [KW-1:0] k,
  output logic [W-1:0]  c
);
  logic [7:0] base;

  always_comb begin
    base = 8'h00;
    if (!neg) begin
      case (k)
        KW'(1): base = 8'hC7;
        KW'(2): base = 8'hC4;
        KW'(3): base = 8'hC2;
        KW'(4): base = 8'hC1;
        KW'(5), KW'(6), KW'(7): base = 8'hC0;
        default: base = 8'h00;
      endcase
    end else begin
      case (k)
        KW'(1): base = 8'h4A;
        KW'(2): base = 8'h44;
        KW'(3): base = 8'h42;
        KW'(4), KW'(5): base = 8'h41;
        KW'(6), KW'(7): base = 8'h40;
        default: base = 8'h00;
      endcase
    end
  end

  generate
    if (W == 8) begin : g_native
      assign c = base;
    end else begin : g_wide
      assign c = {{(W-8){base[7]}}, base} << (W-8);
    end
  endgenerate
endmodule

// File: rtl/rnr_next.sv
// Combinational next residual for a nonzero digit (R6, R7, R8 first phase).
module rnr_next #(
  parameter int W  = 8,
  parameter int KW = 3
) (
  input  logic [W-1:0]  u,
  input  logic [KW-1:0] k,
  input  logic          neg,
  input  logic          is_divlog,
  input  logic          is_exp,
  input  logic [W-1:0]  cst,
  output logic [W-1:0]  sum,
  output logic [W-1:0]  dbl
);
  logic signed [W-1:0] shr;
  logic [W-1:0] opa, opb;
  logic cin;

  assign shr = $signed(u) >>> k;
  assign dbl = {u[W-2:0], 1'b0};

  always_comb begin
    if (is_exp) begin
      opa = u;
      opb = cst;
      cin = 1'b0;
    end else begin
      // doubling plus or minus one: flip the new sign bit
      opa = {~u[W-2], u[W-3:0], 1'b0};
      if (is_divlog) begin
        opb = neg ? ~shr : shr;
        cin = neg;
      end else begin
        opb = '0;
        cin = 1'b0;
      end
    end
    sum = opa + opb + {{(W-1){1'b0}}, cin};
  end
endmodule

// File: rtl/resid_norm_core.sv
module resid_norm_core
  import rnr_pkg::*;
#(
  parameter int W  = 8,
  parameter int KW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    op_code,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic          step,
  output logic [W-1:0]  resid,
  output logic          dig_nz,
  output logic          dig_neg,
  output logic [KW-1:0] step_idx,
  output logic          done
);
  localparam logic [KW-1:0] K_FIRST = KW'(1);
  localparam logic [KW-1:0] K_LAST  = '1;

  logic [W-1:0]  u_q;
  logic [KW-1:0] k_q;
  logic          pend_q;
  logic          is_divlog, is_exp;
  logic [W-1:0]  cst, sum, dbl;

  assign is_divlog = (op_code == OP_DIV) || (op_code == OP_LOG);
  assign is_exp    = (op_code == OP_EXP);

  rnr_digit_sel #(.W(W)) u_sel (
    .u          (u_q),
    .toward_neg (is_divlog),
    .nz         (dig_nz),
    .neg        (dig_neg)
  );

  rnr_exp_const #(.W(W), .KW(KW)) u_cst (
    .neg (dig_neg),
    .k   (k_q),
    .c   (cst)
  );

  rnr_next #(.W(W), .KW(KW)) u_nxt (
    .u         (u_q),
    .k         (k_q),
    .neg       (dig_neg),
    .is_divlog (is_divlog),
    .is_exp    (is_exp),
    .cst       (cst),
    .sum       (sum),
    .dbl       (dbl)
  );

  assign done     = (k_q == K_LAST);
  assign resid    = u_q;
  assign step_idx = k_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      u_q    <= '0;
      k_q    <= K_FIRST;
      pend_q <= 1'b0;
    end else if (load) begin
      u_q    <= load_val;
      k_q    <= K_FIRST;
      pend_q <= 1'b0;
    end else if (pend_q) begin
      u_q    <= dbl;
      k_q    <= k_q + 1'b1;
      pend_q <= 1'b0;
    end else if (step && !done) begin
      if (!dig_nz) begin
        u_q <= dbl;
        k_q <= k_q + 1'b1;
      end else if (is_exp) begin
        u_q    <= sum;
        pend_q <= 1'b1;
      end else begin
        u_q <= sum;
        k_q <= k_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rnr_chk.sv
module rnr_chk #(
  parameter int W  = 8,
  parameter int KW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    op_code,
  input logic          load,
  input logic [W-1:0]  load_val,
  input logic          step,
  input logic [W-1:0]  resid,
  input logic          dig_nz,
  input logic          dig_neg,
  input logic [KW-1:0] step_idx,
  input logic          done,
  input logic          pend_q
);
  localparam int TH = 3 << (W-4);
  logic take;
  assign take = !load && step && !pend_q && !done;

  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (resid == $past(load_val) && step_idx == KW'(1) && !pend_q));

  a_r3_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    dig_nz == (($signed(resid) >= TH) || ($signed(resid) < -TH)));

  a_r4_sign_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dig_neg |-> dig_nz);

  a_r4_sign_divlog: assert property (@(posedge clk) disable iff (!rst_n)
    (dig_nz && (op_code == 3'b111 || op_code == 3'b101)) |-> (dig_neg == !resid[W-1]));

  a_r5_zero_digit: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !dig_nz) |=> (resid == {$past(resid[W-2:0]), 1'b0}));

  a_r7_mul_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dig_nz && op_code == 3'b011) |=>
      (resid == {~$past(resid[W-2]), $past(resid[W-3:0]), 1'b0}));

  a_r8_auto_double: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && pend_q) |=> (!pend_q && resid == {$past(resid[W-2:0]), 1'b0}
                           && step_idx == KW'($past(step_idx) + 1'b1)));

  a_r9_hold_done: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && done) |=> ($stable(resid) && $stable(step_idx)));

  a_r9_idx_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    step_idx != '0);
endmodule

bind resid_norm_core rnr_chk #(.W(W), .KW(KW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_code  (op_code),
  .load     (load),
  .load_val (load_val),
  .step     (step),
  .resid    (resid),
  .dig_nz   (dig_nz),
  .dig_neg  (dig_neg),
  .step_idx (step_idx),
  .done     (done),
  .pend_q   (pend_q)
);

// File: tb/resid_norm_core_test.sv
`timescale 1ns/1ps
module resid_norm_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = 3'b111;
  logic       ld = 1'b0, st = 1'b0;
  logic [7:0] lv = 8'h00;
  logic [7:0] resid;
  logic       dig_nz, dig_neg, done;
  logic [2:0] step_idx;

  int checks = 0;
  int errors = 0;
  logic [13:0] exp_q[$];
  string       tag_q[$];

  int mu = 0, mk = 1, mpend = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #10 clk = ~clk;

  resid_norm_core uut (
    .clk(clk), .rst_n(rst_n), .op_code(op), .load(ld), .load_val(lv),
    .step(st), .resid(resid), .dig_nz(dig_nz), .dig_neg(dig_neg),
    .step_idx(step_idx), .done(done)
  );

  function automatic int wrap8(input int x);
    int r;
    r = x & 255;
    if (r >= 128) r = r - 256;
    return r;
  endfunction

  // R8 constant from its definition
  function automatic int cst(input int s, input int k);
    real p, x;
    p = 1.0;
    for (int i = 0; i < k; i++) p = p * 2.0;
    x = p * -$ln(1.0 + s / (p * 2.0)) * 128.0;
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  function automatic int digit(input int v, input logic [2:0] o);
    bit divlog;
    divlog = (o == 3'b111) || (o == 3'b101);
    if (!(v >= 48 || v < -48)) return 0;
    if (divlog) return (v >= 0) ? -1 : 1;
    return (v >= 0) ? 1 : -1;
  endfunction

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // driver: apply one cycle of stimulus, push the expected outcome
  task automatic cyc(input logic [2:0] o, input bit l, input int val, input bit s_);
    string tag;
    int s;
    #1;
    op = o; ld = l; lv = val[7:0]; st = s_;
    if (l) begin
      mu = wrap8(val); mk = 1; mpend = 0; tag = "R2";
    end else if (mpend != 0) begin
      mu = wrap8(2 * mu); mk++; mpend = 0; tag = "R8";
    end else if (s_ && mk != 7) begin
      s = digit(mu, o);
      if (s == 0) begin
        mu = wrap8(2 * mu); mk++; tag = "R5";
      end else if (o == 3'b110) begin
        mu = wrap8(mu + cst(s, mk)); mpend = 1; tag = "R8";
      end else if (o == 3'b111 || o == 3'b101) begin
        mu = wrap8(2 * mu + s * 128 + s * (mu >>> mk)); mk++; tag = "R6";
      end else begin
        mu = wrap8(2 * mu - s * 128); mk++; tag = "R7";
      end
    end else begin
      tag = "R9";
    end
    @(posedge clk);
    #1;
    s = digit(mu, o);
    exp_q.push_back({mu[7:0], mk[2:0], (mk == 7), (s != 0), (s < 0)});
    tag_q.push_back(tag);
    ld = 1'b0; st = 1'b0;
    @(negedge clk);
  endtask

  // monitor: compare at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      logic [13:0] e;
      string t;
      bit bad;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      bad = 0;
      if (resid !== e[13:6] || step_idx !== e[5:3] || done !== e[2]) begin
        $display("FAIL %s: resid %h idx %0d done %b, expected %h %0d %b",
                 t, resid, step_idx, done, e[13:6], e[5:3], e[2]);
        bad = 1;
      end
      if (dig_nz !== e[1]) begin
        $display("FAIL R3: dig_nz %b expected %b (resid %h)", dig_nz, e[1], e[13:6]);
        bad = 1;
      end
      if (dig_neg !== e[0]) begin
        $display("FAIL R4: dig_neg %b expected %b (resid %h op %b)", dig_neg, e[0], e[13:6], op);
        bad = 1;
      end
      if (bad) errors++;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    $display("FAIL watchdog: run did not finish, expected completion");
    errors++;
    finish_up();
  end

  initial begin
    logic [2:0] ops [4];
    logic [7:0] edges [6];
    ops[0] = 3'b111; ops[1] = 3'b011; ops[2] = 3'b101; ops[3] = 3'b110;
    edges[0] = 8'h2F; edges[1] = 8'h30; edges[2] = 8'hCF;
    edges[3] = 8'hD0; edges[4] = 8'h7F; edges[5] = 8'h80;

    repeat (3) @(negedge clk);
    checks++;  // R1 reset state
    if (resid !== 8'h00 || step_idx !== 3'd1 || done !== 1'b0) begin
      $display("FAIL R1: resid %h idx %0d done %b, expected 00 1 0", resid, step_idx, done);
      errors++;
    end
    #1 rst_n = 1'b1;
    mu = 0; mk = 1; mpend = 0;
    @(negedge clk);

    // R3/R4 threshold neighbours under each opcode, then one step
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 6; j++) begin
        cyc(ops[i], 1, edges[j], 0);
        cyc(ops[i], 0, 0, 1);
        cyc(ops[i], 0, 0, 1);  // lands in R8 doubling for exponential
      end

    // R2: load wins over a simultaneous step
    cyc(3'b111, 1, 8'h50, 0);
    cyc(3'b111, 0, 0, 1);
    cyc(3'b111, 1, 8'hA0, 1);

    // long sequences past done, with idle cycles and pending strobes
    for (int i = 0; i < 4; i++)
      for (int n = 0; n < 12; n++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        cyc(ops[i], 1, int'(seed[23:16]), 0);
        for (int c = 0; c < 16; c++)
          cyc(ops[i], 0, 0, (c % 5) != 3);  // R9 idle cycles mixed in
      end

    // R8: load during pending doubling cancels it
    cyc(3'b110, 1, 8'h60, 0);
    cyc(3'b110, 0, 0, 1);
    cyc(3'b110, 1, 8'h10, 0);
    cyc(3'b110, 0, 0, 1);

    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule